// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block holds the 32-bit status word of one timer/capture channel. It latches an event flag when an input-capture or compare-match pulse arrives. It records an overrun when a further event lands while that flag is still pending, and it latches a sticky counter-overflow indication. The same word also shows the live level of the channel's synchronized input pin and of its output pin. The counter, the comparators, the input filter and the DMA engine live outside the block and arrive as one-cycle strobes and plain levels.

Software reads and clears the word over a simple single-cycle register bus at byte offset 0x10 of the channel's address block. Latched bits clear by write-one-to-clear. When the channel's DMA mode is on, the event flag is instead retired by a hardware acknowledge from the DMA controller. The pending flag is presented as an interrupt request, or as a DMA request when DMA mode is on.

Top module: `chan_status_reg`

## Requirements
- R1: After reset the flag, overrun and overflow bits are 0, and both `irqReq` and `dmaReq` are low.
- R2: A high `evtCapture` or `evtMatch` in a cycle sets the event flag at that clock edge; it reads as bit 0 (the LSB) of the word at offset 0x10.
- R3: An event that arrives while the event flag is already 1 sets the overrun bit, which reads as bit 31 (the MSB).
- R4: With DMA mode off, writing 1 to bit 0 clears the event flag, and it clears the overrun bit with it.
- R5: Writing 1 to bit 31 clears only the overrun bit and leaves the event flag set.
- R6: A high `cntOverflow` sets the overflow bit (bit 15). Only a write of 1 to bit 15 clears it. Clearing the event flag by any means leaves it unchanged.
- R7: Bit 2 reads the live `pinIn` level and bit 1 the live `pinOut` level. All other bits read 0. A read at any offset other than 0x10 returns 0.
- R8: Writing 0 to a bit, writing to the read-only or reserved bits, and writing at any offset other than 0x10 all change no state.
- R9: When a set (an event, or `cntOverflow`) and a clear of the same bit fall in one cycle, the set wins.
- R10: With `dmaEn` high, a high `dmaAck` clears the event flag and the overrun bit, and a software write of 1 to bit 0 is ignored. With `dmaEn` low, `dmaAck` has no effect.
- R11: `irqReq` equals the event flag while `dmaEn` is low, and `dmaReq` equals the event flag while `dmaEn` is high. The request that is not selected stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset within the channel block |
| busWdata | input | 32 | Write data (1 = clear the bit) |
| busRdata | output | 32 | Read data, same cycle, 0 when no read hits |
| evtCapture | input | 1 | Input-capture event strobe |
| evtMatch | input | 1 | Comparator-match event strobe |
| cntOverflow | input | 1 | Internal counter overflow strobe |
| pinIn | input | 1 | Filtered, synchronized input pin level |
| pinOut | input | 1 | Current output pin level |
| dmaEn | input | 1 | Channel DMA mode enable |
| dmaAck | input | 1 | DMA controller acknowledge (clears flag) |
| irqReq | output | 1 | Interrupt request (flag, DMA mode off) |
| dmaReq | output | 1 | DMA request (flag, DMA mode on) |

## Verification
A wrong flag or overrun state is visible at once: the request outputs follow the flag combinationally in the next cycle, and a read shows all three latched bits in the cycle after the edge that changed them. A missed set-wins priority or a lost DMA-mode gate shows up as a flag that reads 0 right after a cycle that held both an event and a clear. A broken overrun-to-flag coupling leaves bit 31 at 1 on the first read after the flag clears. The bench follows every cycle with a reference model and compares the request outputs in every cycle and the full word on every read.

// File: rtl/chan_status_pkg.sv
package chan_status_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 8;
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h10;

  // bit positions are given with bit 0 as the MSB; convert to LSB indices
  localparam int MSB_OVR  = 0;
  localparam int MSB_OVFL = 16;
  localparam int MSB_PIN  = 29;
  localparam int MSB_POUT = 30;
  localparam int MSB_FLAG = 31;
  localparam int BIT_OVR  = DATA_W - 1 - MSB_OVR;
  localparam int BIT_OVFL = DATA_W - 1 - MSB_OVFL;
  localparam int BIT_PIN  = DATA_W - 1 - MSB_PIN;
  localparam int BIT_POUT = DATA_W - 1 - MSB_POUT;
  localparam int BIT_FLAG = DATA_W - 1 - MSB_FLAG;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic setOvr;
    logic clrOvr;
    logic setOvfl;
    logic clrOvfl;
  } stsStrobe_t;
endpackage

// File: rtl/chan_status_ctrl.sv
module chan_status_ctrl
  import chan_status_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              evtCapture,
  input  logic              evtMatch,
  input  logic              cntOverflow,
  input  logic              dmaEn,
  input  logic              dmaAck,
  input  logic              flagNow,
  output logic              rdHit,
  output stsStrobe_t        strobe
);
  logic addrHit;
  logic wrHit;
  logic anyEvt;
  logic swFlagClr;
  logic hwFlagClr;

  always_comb begin
    addrHit   = busSel && (busAddr == REG_OFS);
    wrHit     = addrHit && busWr;
    rdHit     = addrHit && !busWr;
    anyEvt    = evtCapture || evtMatch;
    // software clear of the flag only counts outside DMA mode
    swFlagClr = wrHit && busWdata[BIT_FLAG] && !dmaEn;
    hwFlagClr = dmaEn && dmaAck;

    strobe.setFlag = anyEvt;
    strobe.clrFlag = swFlagClr || hwFlagClr;
    strobe.setOvr  = anyEvt && flagNow;
    strobe.clrOvr  = (wrHit && busWdata[BIT_OVR]) || swFlagClr || hwFlagClr;
    strobe.setOvfl = cntOverflow;
    strobe.clrOvfl = wrHit && busWdata[BIT_OVFL];
  end
endmodule

// File: rtl/chan_status_dp.sv
module chan_status_dp
  import chan_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stsStrobe_t        strobe,
  input  logic              rdHit,
  input  logic              pinIn,
  input  logic              pinOut,
  input  logic              dmaEn,
  output logic              flagQ,
  output logic              ovrQ,
  output logic              ovflQ,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic              dmaReq
);
  logic [DATA_W-1:0] statusWord;

  // set has priority over clear on every latched bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      ovrQ  <= 1'b0;
      ovflQ <= 1'b0;
    end else begin
      if (strobe.setFlag)      flagQ <= 1'b1;
      else if (strobe.clrFlag) flagQ <= 1'b0;
      if (strobe.setOvr)       ovrQ  <= 1'b1;
      else if (strobe.clrOvr)  ovrQ  <= 1'b0;
      if (strobe.setOvfl)      ovflQ <= 1'b1;
      else if (strobe.clrOvfl) ovflQ <= 1'b0;
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_OVR]  = ovrQ;
    statusWord[BIT_OVFL] = ovflQ;
    statusWord[BIT_PIN]  = pinIn;
    statusWord[BIT_POUT] = pinOut;
    statusWord[BIT_FLAG] = flagQ;
    busRdata = rdHit ? statusWord : '0;
    irqReq   = flagQ && !dmaEn;
    dmaReq   = flagQ && dmaEn;
  end
endmodule

// File: rtl/chan_status_reg.sv
module chan_status_reg
  import chan_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        evtCapture,
  input  logic        evtMatch,
  input  logic        cntOverflow,
  input  logic        pinIn,
  input  logic        pinOut,
  input  logic        dmaEn,
  input  logic        dmaAck,
  output logic        irqReq,
  output logic        dmaReq
);
  stsStrobe_t strobe;
  logic       rdHit;
  logic       flagQ;
  logic       ovrQ;
  logic       ovflQ;

  chan_status_ctrl u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .evtCapture(evtCapture), .evtMatch(evtMatch), .cntOverflow(cntOverflow),
    .dmaEn(dmaEn), .dmaAck(dmaAck), .flagNow(flagQ),
    .rdHit(rdHit), .strobe(strobe)
  );

  chan_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdHit(rdHit),
    .pinIn(pinIn), .pinOut(pinOut), .dmaEn(dmaEn),
    .flagQ(flagQ), .ovrQ(ovrQ), .ovflQ(ovflQ),
    .busRdata(busRdata), .irqReq(irqReq), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/chan_status_chk.sv
module chan_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        evtCapture,
  input logic        evtMatch,
  input logic        cntOverflow,
  input logic        dmaEn,
  input logic        dmaAck,
  input logic        irqReq,
  input logic        dmaReq,
  input logic        flagQ,
  input logic        ovrQ,
  input logic        ovflQ
);
  logic anyEvt;
  logic ovflWr;
  assign anyEvt = evtCapture || evtMatch;
  assign ovflWr = busSel && busWr && (busAddr == 8'h10) && busWdata[15];

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt |=> flagQ); // R2
  AST_REPEAT_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (anyEvt && flagQ) |=> ovrQ); // R3
  AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ovrQ |-> flagQ); // R4
  AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovflQ && !ovflWr) |=> ovflQ); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & 32'h7FFF_7FF8) == 32'h0); // R7
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEn && flagQ && !dmaAck) |=> flagQ); // R10
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && dmaReq)); // R11
endmodule

bind chan_status_reg chan_status_chk u_chk (.*);

// File: tb/sim_chan_status_reg.sv
`timescale 1ns/1ps
module sim_chan_status_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        evtCapture = 1'b0, evtMatch = 1'b0, cntOverflow = 1'b0;
  logic        pinIn = 1'b0, pinOut = 1'b0, dmaEn = 1'b0, dmaAck = 1'b0;
  logic        irqReq, dmaReq;

  int total = 0;
  int bad = 0;
  logic mFlag = 1'b0, mOvr = 1'b0, mOvfl = 1'b0;

  always #2.5 clk = ~clk;

  chan_status_reg u0 (.*);

  function automatic logic [2:0] modelNext(logic [2:0] st, logic evt, logic ovf,
      logic wrHit, logic [31:0] wd, logic dEn, logic ack);
    logic f, o, v, fClr;
    {o, v, f} = st;
    fClr = (wrHit && wd[0] && !dEn) || (dEn && ack);
    modelNext[0] = evt ? 1'b1 : (fClr ? 1'b0 : f);
    modelNext[2] = (evt && f) ? 1'b1 : ((fClr || (wrHit && wd[31])) ? 1'b0 : o);
    modelNext[1] = ovf ? 1'b1 : ((wrHit && wd[15]) ? 1'b0 : v);
  endfunction

  function automatic logic [31:0] expWord(logic hit, logic pIn, logic pOut);
    expWord = hit ? {mOvr, 15'h0, mOvfl, 12'h0, pIn, pOut, mFlag} : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(string req, logic cap, logic mat, logic ovf, logic sel, logic wr,
      logic [7:0] adr, logic [31:0] wd, logic dEn, logic ack, logic pI, logic pO);
    logic hit;
    @(negedge clk);
    evtCapture = cap; evtMatch = mat; cntOverflow = ovf;
    busSel = sel; busWr = wr; busAddr = adr; busWdata = wd;
    dmaEn = dEn; dmaAck = ack; pinIn = pI; pinOut = pO;
    #1;
    hit = sel && (adr == 8'h10);
    check("R11", {30'h0, irqReq, dmaReq}, {30'h0, mFlag && !dEn, mFlag && dEn});
    if (sel && !wr) check(req, busRdata, expWord(hit, pI, pO));
    @(posedge clk);
    {mOvr, mOvfl, mFlag} = modelNext({mOvr, mOvfl, mFlag}, cap || mat, ovf,
                                     hit && wr, wd, dEn, ack);
  endtask

  task automatic rd(string req, logic dEn = 1'b0);
    cyc(req, 0, 0, 0, 1, 0, 8'h10, 32'h0, dEn, 0, pinIn, pinOut);
  endtask

  task automatic wr(logic [31:0] wd, logic dEn = 1'b0, logic [7:0] adr = 8'h10);
    cyc("wr", 0, 0, 0, 1, 1, adr, wd, dEn, 0, pinIn, pinOut);
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #12 rstN = 1'b1;
    rd("R1");                                        // reset state
    cyc("R2", 1, 0, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0);   // capture event
    rd("R2");
    cyc("R3", 0, 1, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0);   // second event -> overrun
    rd("R3");
    wr(32'h8000_0000); rd("R5");                     // clear overrun only
    cyc("R3", 1, 0, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0);
    wr(32'h0000_0000); rd("R8");                     // write zero
    wr(32'hFFFF_FFFF, 1'b0, 8'h14); rd("R8");        // wrong offset
    wr(32'h7FFF_7FFE); rd("R8");                     // reserved + pin bits
    wr(32'h0000_0001); rd("R4");                     // flag clear drops overrun
    cyc("R6", 0, 0, 1, 0, 0, 8'h0, 0, 0, 0, 0, 0);
    wr(32'h0000_0001); rd("R6");                     // flag clear keeps overflow
    cyc("R9", 0, 0, 1, 1, 1, 8'h10, 32'h0000_8000, 0, 0, 0, 0);
    rd("R9");
    wr(32'h0000_8000); rd("R6");
    cyc("R7", 0, 0, 0, 1, 0, 8'h10, 0, 0, 0, 1, 0);
    cyc("R7", 0, 0, 0, 1, 0, 8'h10, 0, 0, 0, 0, 1);
    cyc("R7", 0, 0, 0, 1, 0, 8'h20, 0, 0, 0, 1, 1);
    cyc("R9", 1, 0, 0, 1, 1, 8'h10, 32'h0000_0001, 0, 0, 0, 0);
    rd("R9");
    wr(32'h0000_0001, 1'b1); rd("R10", 1'b1);        // sw clear ignored in DMA mode
    cyc("R10", 1, 0, 0, 0, 0, 8'h0, 0, 1, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 8'h0, 0, 1, 1, 0, 0);  // ack clears flag+overrun
    rd("R10", 1'b1);
    cyc("R2", 0, 1, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 8'h0, 0, 0, 1, 0, 0);  // ack ignored outside DMA
    rd("R10");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] wd;
      logic [2:0]  pick;
      logic        dEn;
      pick = 3'($urandom_range(0, 7));
      wd = {$urandom_range(0,1) == 1, 15'($urandom), $urandom_range(0,1) == 1,
            15'($urandom)};
      dEn = ($urandom_range(0, 3) == 0);
      cyc((pick < 3) ? "R8" : "R9",
          $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 2) != 0, pick < 3,
          ($urandom_range(0, 5) == 0) ? 8'h0C : 8'h10, wd, dEn,
          $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule